// File: doc/BRIEF.md
# Burst Read Subordinate with Per-Beat Response

This block answers AXI4 read requests from a small on-chip register array. A manager presents one burst descriptor (start address, beat count minus one, beat size and burst type) on the read-address channel. The block takes it in a single handshake and then streams the requested number of beats back on the read-data channel. Each beat carries one data word and its own response code, and the last beat is marked.

The controller has only two phases: waiting for an address, and sending beats. It needs no separate response phase because every beat carries its own status. The data for the first beat is looked up in the same cycle that the address is accepted. When a non-final beat is taken, the next beat is loaded in that same cycle, so an always-ready manager receives one beat per clock with no gap. The address of each beat is derived from the previous one according to the burst type. A beat that lands outside the array, or inside a configurable faulty window, reports an error on that beat alone.

The array holds DATA_W-bit words and is loaded with a fixed pattern while reset is asserted. The block is a read-only test target: for example, a stand-in memory behind an interconnect port.

Top module: `axrd_slave`

## Requirements
- R1: While the synchronous active-low reset is held, rvalid is 0. In the first cycle after reset is released, arready is 1 and rvalid is 0.
- R2: arready is high only when no burst is in progress. arready and rvalid are never high in the same cycle.
- R3: In the cycle after an address handshake, rvalid is 1 and rdata/rresp describe the start address.
- R4: A burst delivers exactly arlen+1 beats. rlast is 1 on the final beat and 0 on every earlier beat.
- R5: While rvalid is 1 and rready is 0, rvalid stays 1 and rdata, rresp and rlast keep their values.
- R6: After a non-final beat is accepted, rvalid is 1 in the next cycle and already carries the next beat.
- R7: After the final beat is accepted, rvalid is 0 and arready is 1 in the next cycle.
- R8: With arburst = 2'b00 (fixed), every beat uses the start address.
- R9: With arburst = 2'b01 (incrementing), each beat address is the previous one plus 2^arsize. The reserved code 2'b11 behaves the same way.
- R10: With arburst = 2'b10 (wrapping) and arlen of 1, 3, 7 or 15, each beat address adds 2^arsize. When the address reaches the top of the aligned window of (arlen+1)·2^arsize bytes, it returns to the bottom of that window.
- R11: A wrapping burst with any other arlen is addressed as an incrementing burst.
- R12: A beat whose byte address is at or above WORDS·DATA_W/8, or inside [ERR_LO, ERR_HI), returns rresp = 2'b10 with rdata = 0. Every other beat returns rresp = 2'b00. The status is decided beat by beat.
- R13: A good beat returns the whole word with index address/(DATA_W/8), whatever arsize is. With the defaults, word k holds k·32'h01010101 + 32'h10000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready (high in idle phase) |
| araddr | input | ADDR_W | Burst start byte address |
| arlen | input | 8 | Beats in burst minus one |
| arsize | input | 3 | log2 of bytes per beat |
| arburst | input | 2 | Burst type: 00 fixed, 01 incrementing, 10 wrapping |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Manager accepts read data |
| rdata | output | DATA_W | Beat data word |
| rresp | output | 2 | Beat status: 00 okay, 10 error |
| rlast | output | 1 | Final beat of the burst |

## Verification
The assertions assume that the manager holds the address channel stable while arvalid is high, and that the start address is aligned to 2^arsize. They also assume that arsize never asks for more bytes than one data word holds. Their beat counting relies on the block taking only one burst at a time. The stimulus raises arvalid for exactly one handshake per burst, and it drives arsize only from 0 to 2 with start addresses rounded down to that size. Start addresses stay in a range that exercises the out-of-range and error-window paths without wrapping the address width. Wrapping lengths come from the legal set, except for one directed case that checks the fall-back to incrementing. rready is stalled at random, at rates from 0 to 70 percent.

// File: rtl/axrd_pkg.sv
package axrd_pkg;

    typedef enum logic [1:0] {
        BURST_FIXED = 2'b00,
        BURST_INCR  = 2'b01,
        BURST_WRAP  = 2'b10,
        BURST_RSVD  = 2'b11
    } burst_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SEND = 1'b1
    } phase_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

    localparam int LEN_W  = 8;
    localparam int SIZE_W = 3;

endpackage

// File: rtl/axrd_addr_step.sv
module axrd_addr_step
    import axrd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [SIZE_W-1:0] size,
    input  burst_e            burst,
    output logic [ADDR_W-1:0] nxt_addr
);

    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] bumped;
    logic              wrap_len_ok;

    always_comb begin
        step        = ADDR_W'(1) << size;
        span        = ADDR_W'({1'b0, len} + 9'd1) << size;
        mask        = span - ADDR_W'(1);
        bumped      = cur_addr + step;
        wrap_len_ok = (len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15);

        unique case (burst)
            BURST_FIXED: nxt_addr = cur_addr;
            BURST_WRAP: begin
                if (wrap_len_ok) begin
                    nxt_addr = (cur_addr & ~mask) | (bumped & mask);
                end else begin
                    nxt_addr = bumped;
                end
            end
            default:     nxt_addr = bumped;
        endcase
    end

endmodule

// File: rtl/axrd_store.sv
module axrd_store
    import axrd_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter int          DATA_W = 32,
    parameter int          WORDS  = 64,
    parameter int unsigned ERR_LO = 32'h00C0,
    parameter int unsigned ERR_HI = 32'h00D0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] look_addr,
    output logic [DATA_W-1:0] look_data,
    output logic [1:0]        look_resp
);

    localparam int BYTES_PER = DATA_W / 8;
    localparam int OFF_W     = (BYTES_PER > 1) ? $clog2(BYTES_PER) : 1;
    localparam int IDX_W     = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int LIMIT     = WORDS * BYTES_PER;

    logic [DATA_W-1:0] cells_q [WORDS];

    function automatic logic [DATA_W-1:0] fill_word(input int k);
        return DATA_W'(32'(k) * 32'h0101_0101 + 32'h1000_0000);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < WORDS; k++) begin
                cells_q[k] <= fill_word(k);
            end
        end
    end

    logic              in_range;
    logic              in_fault;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        in_range = ({1'b0, look_addr} < (ADDR_W+1)'(LIMIT));
        in_fault = (look_addr >= ADDR_W'(ERR_LO)) && (look_addr < ADDR_W'(ERR_HI));
        idx      = look_addr[OFF_W +: IDX_W];
        if (in_range && !in_fault) begin
            look_data = cells_q[idx];
            look_resp = RESP_OKAY;
        end else begin
            look_data = '0;
            look_resp = RESP_SLVERR;
        end
    end

endmodule

// File: rtl/axrd_slave.sv
module axrd_slave
    import axrd_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter int          DATA_W = 32,
    parameter int          WORDS  = 64,
    parameter int unsigned ERR_LO = 32'h00C0,
    parameter int unsigned ERR_HI = 32'h00D0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arvalid,
    output logic              arready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic [7:0]        arlen,
    input  logic [2:0]        arsize,
    input  logic [1:0]        arburst,
    output logic              rvalid,
    input  logic              rready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rlast
);

    typedef struct packed {
        phase_e              phase;
        logic [ADDR_W-1:0]   addr;
        logic [LEN_W-1:0]    len;
        logic [SIZE_W-1:0]   size;
        burst_e              burst;
        logic [LEN_W-1:0]    beat;
        logic                rvalid;
        logic [DATA_W-1:0]   rdata;
        logic [1:0]          rresp;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [ADDR_W-1:0] step_addr;
    logic [ADDR_W-1:0] look_addr;
    logic [DATA_W-1:0] look_data;
    logic [1:0]        look_resp;
    logic              final_beat;

    axrd_addr_step #(
        .ADDR_W (ADDR_W)
    ) u_step (
        .cur_addr (ctl_q.addr),
        .len      (ctl_q.len),
        .size     (ctl_q.size),
        .burst    (ctl_q.burst),
        .nxt_addr (step_addr)
    );

    // One lookup port: start address while idle, next beat address while sending.
    assign look_addr = (ctl_q.phase == PH_IDLE) ? araddr : step_addr;

    axrd_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WORDS  (WORDS),
        .ERR_LO (ERR_LO),
        .ERR_HI (ERR_HI)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_addr (look_addr),
        .look_data (look_data),
        .look_resp (look_resp)
    );

    assign final_beat = (ctl_q.phase == PH_SEND) && (ctl_q.beat == ctl_q.len);

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (arvalid) begin
                    ctl_d.addr   = araddr;
                    ctl_d.len    = arlen;
                    ctl_d.size   = arsize;
                    ctl_d.burst  = burst_e'(arburst);
                    ctl_d.beat   = '0;
                    ctl_d.rdata  = look_data;
                    ctl_d.rresp  = look_resp;
                    ctl_d.rvalid = 1'b1;
                    ctl_d.phase  = PH_SEND;
                end
            end
            PH_SEND: begin
                if (ctl_q.rvalid && rready) begin
                    if (final_beat) begin
                        ctl_d.rvalid = 1'b0;
                        ctl_d.phase  = PH_IDLE;
                    end else begin
                        ctl_d.addr  = step_addr;
                        ctl_d.beat  = ctl_q.beat + 8'd1;
                        ctl_d.rdata = look_data;
                        ctl_d.rresp = look_resp;
                    end
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.phase  <= PH_IDLE;
            ctl_q.addr   <= '0;
            ctl_q.len    <= '0;
            ctl_q.size   <= '0;
            ctl_q.burst  <= BURST_INCR;
            ctl_q.beat   <= '0;
            ctl_q.rvalid <= 1'b0;
            ctl_q.rdata  <= '0;
            ctl_q.rresp  <= RESP_OKAY;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign arready = (ctl_q.phase == PH_IDLE);
    assign rvalid  = ctl_q.rvalid;
    assign rdata   = ctl_q.rdata;
    assign rresp   = ctl_q.rresp;
    assign rlast   = final_beat;

endmodule

// File: rtl/axrd_slave_chk.sv
module axrd_slave_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arvalid,
    input logic              arready,
    input logic [7:0]        arlen,
    input logic              rvalid,
    input logic              rready,
    input logic [DATA_W-1:0] rdata,
    input logic [1:0]        rresp,
    input logic              rlast
);

    logic [7:0] seen_q;
    logic [7:0] want_q;
    logic       rst_seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q     <= '0;
            want_q     <= '0;
            rst_seen_q <= 1'b0;
        end else begin
            rst_seen_q <= 1'b1;
            if (arvalid && arready) begin
                want_q <= arlen;
                seen_q <= '0;
            end else if (rvalid && rready) begin
                seen_q <= seen_q + 8'd1;
            end
        end
    end

    // R1: first cycle out of reset is idle
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_seen_q |-> (arready && !rvalid));

    assert_chan_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arready != rvalid);

    assert_first_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid && arready) |=> (rvalid && !arready));

    assert_beat_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (rlast == (seen_q == want_q)));

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(rresp) && $stable(rlast)));

    assert_no_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && rready && !rlast) |=> rvalid);

    assert_burst_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && rready && rlast) |=> (!rvalid && arready));

    assert_resp_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> ((rresp == 2'b00) || ((rresp == 2'b10) && (rdata == '0))));

endmodule

bind axrd_slave axrd_slave_chk #(
    .DATA_W (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .arvalid (arvalid),
    .arready (arready),
    .arlen   (arlen),
    .rvalid  (rvalid),
    .rready  (rready),
    .rdata   (rdata),
    .rresp   (rresp),
    .rlast   (rlast)
);

// File: tb/axrd_slave_test.sv
`timescale 1ns/1ps
module axrd_slave_test;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              arvalid = 1'b0;
    logic              arready;
    logic [ADDR_W-1:0] araddr = '0;
    logic [7:0]        arlen = '0;
    logic [2:0]        arsize = '0;
    logic [1:0]        arburst = '0;
    logic              rvalid;
    logic              rready = 1'b0;
    logic [DATA_W-1:0] rdata;
    logic [1:0]        rresp;
    logic              rlast;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    axrd_slave uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .arvalid (arvalid),
        .arready (arready),
        .araddr  (araddr),
        .arlen   (arlen),
        .arsize  (arsize),
        .arburst (arburst),
        .rvalid  (rvalid),
        .rready  (rready),
        .rdata   (rdata),
        .rresp   (rresp),
        .rlast   (rlast)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Model of R12/R13
    function automatic bit is_bad(input logic [15:0] a);
        return (a >= 16'h0100) || (a >= 16'h00C0 && a < 16'h00D0);
    endfunction

    function automatic logic [31:0] want_data(input logic [15:0] a);
        if (is_bad(a)) return 32'h0;
        return 32'(a >> 2) * 32'h0101_0101 + 32'h1000_0000;
    endfunction

    // Model of R8..R11
    function automatic logic [15:0] want_next(input logic [15:0] a, input logic [7:0] l,
                                              input logic [2:0] s, input logic [1:0] b);
        int unsigned tot, lo, n;
        n = 32'(a) + (32'd1 << s);
        if (b == 2'b00) return a;
        if (b == 2'b10 && (l == 1 || l == 3 || l == 7 || l == 15)) begin
            tot = (32'(l) + 1) << s;
            lo  = (32'(a) / tot) * tot;
            if (n >= lo + tot) n = lo;
        end
        return 16'(n);
    endfunction

    task automatic run_burst(input logic [15:0] a, input logic [7:0] l, input logic [2:0] s,
                             input logic [1:0] b, input int stall_pct, input string tag);
        logic [15:0] ea;
        @(negedge clk);
        chk(arready === 1'b1 && rvalid === 1'b0, "R2 idle before burst", {arready, rvalid}, 2'b10);
        arvalid = 1'b1; araddr = a; arlen = l; arsize = s; arburst = b;
        @(negedge clk);
        arvalid = 1'b0;
        chk(rvalid === 1'b1 && arready === 1'b0, "R3 first beat valid", {rvalid, arready}, 2'b10);
        ea = a;
        for (int k = 0; k <= int'(l); k++) begin
            bit took = 1'b0;
            while (!took) begin
                chk(rvalid === 1'b1, (k == 0) ? "R3 rvalid" : "R6 rvalid held", rvalid, 1);
                chk(rdata === want_data(ea), tag, rdata, want_data(ea));
                chk(rresp === (is_bad(ea) ? 2'b10 : 2'b00), "R12 beat resp", rresp, is_bad(ea) ? 2 : 0);
                chk(rlast === (k == int'(l)), "R4 last flag", rlast, (k == int'(l)));
                took = ($urandom_range(99) >= 32'(stall_pct));
                rready = took;
                @(negedge clk);
            end
            rready = 1'b0;
            ea = want_next(ea, l, s, b);
        end
        chk(rvalid === 1'b0 && arready === 1'b1, "R7 burst done", {rvalid, arready}, 2'b01);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(rvalid === 1'b0, "R1 rvalid in reset", rvalid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(arready === 1'b1 && rvalid === 1'b0, "R1 after release", {arready, rvalid}, 2'b10);

        // directed corners
        run_burst(16'h0010, 8'd3, 3'd2, 2'b01, 0,  "R9 incr data");
        run_burst(16'h0038, 8'd3, 3'd2, 2'b10, 0,  "R10 wrap4 data");
        run_burst(16'h0046, 8'd7, 3'd1, 2'b10, 30, "R10 wrap8 half data");
        run_burst(16'h0024, 8'd2, 3'd2, 2'b00, 50, "R8 fixed data");
        run_burst(16'h0014, 8'd2, 3'd2, 2'b10, 0,  "R11 wrap bad len data");
        run_burst(16'h00B8, 8'd5, 3'd2, 2'b01, 20, "R12 err window data");
        run_burst(16'h00F8, 8'd3, 3'd2, 2'b01, 0,  "R12 out of range data");
        run_burst(16'h0021, 8'd0, 3'd0, 2'b01, 0,  "R13 byte beat word data");
        run_burst(16'h0030, 8'd1, 3'd2, 2'b11, 70, "R9 reserved as incr data");
        run_burst(16'h0000, 8'd15, 3'd2, 2'b01, 0, "R4 long burst data");

        // constrained random
        for (int n = 0; n < 60; n++) begin
            logic [2:0]  s = 3'($urandom_range(2));
            logic [1:0]  b = 2'($urandom_range(3));
            logic [7:0]  l;
            logic [15:0] a = 16'($urandom_range(16'h013F));
            a = a & ~((16'd1 << s) - 16'd1);
            if (b == 2'b10) l = 8'((2 << $urandom_range(3)) - 1);
            else            l = 8'($urandom_range(15));
            run_burst(a, l, s, b, int'($urandom_range(70)), "R13 random burst data");
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule